// File: doc/BRIEF.md
# Double-buffered 10-bit PWM generator

This block produces one pulse-width-modulated output from an 8-bit period timer. Below the timer sit two sub-count bits, which give a 10-bit time base and therefore quarter-step duty resolution. A prescaler stretches every time-base step to 1, 4 or 16 input clocks. One period lasts (period + 1) × 4 × prescale input clocks.

A host programs the block through a small write port. It sets the period, the upper eight duty bits, the two lower duty bits and the prescale choice. Duty writes go into a buffer and may arrive at any moment. The buffered value moves into the active duty register only when a new period starts, so a period never carries a half-updated duty. The active value can be read on a dedicated output.

At each period start the output goes high, unless the duty is zero. The output drops when the 10-bit time base reaches the active duty. A duty beyond the end of the period keeps the output high for the whole period. An enable input stops the generator and restarts it on a clean period boundary.

Top module: `pwm10_gen`

## Requirements
- R1: One PWM period lasts exactly 4 × (P + 1) × N input clocks. P is the period register and N is the prescale factor. Each period begins with the output going high on the clock after the previous period's last clock, provided the duty is non-zero.
- R2: Register address 3, data bits [1:0], selects the prescale factor: 00 gives 1, 01 gives 4, 10 and 11 both give 16. Any write to address 3 restarts the prescale count of the current timer step from zero, which lengthens the running period by the clocks already spent in that step.
- R3: Register address 1 holds duty bits [9:2] and address 2, data bits [1:0], holds duty bits [1:0]. Address 0 holds P. For a duty D with 0 < D < 4 × (P + 1), the output is high for D × N clocks at the start of each period and low for the rest.
- R4: With a duty of zero the output stays low for the entire period.
- R5: With a duty of at least 4 × (P + 1) the output is never cleared and stays high for the entire period.
- R6: Duty writes made during a period change neither the output nor the active duty value until the next period starts. At that point the active duty takes the buffered value.
- R7: While enable is low the output is low from the next clock on and the timer is held at zero. On the first enabled clock edge a fresh period begins and the active duty is loaded immediately from the buffer.
- R8: After reset the output is low, the active duty reads zero and all host registers are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Generator enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 period, 1 duty high, 2 duty low, 3 prescale |
| wr_data | input | 8 | Write data |
| pwm_out | output | 1 | PWM output |
| duty_active | output | 10 | Currently latched 10-bit duty (read-only) |

## Verification
The main sweep covers four periods against all four prescale codes. For each pair it tries the duties 0, 1 to 5, half period, one step short of the period, exactly the period and the 10-bit maximum. High-time counts over two consecutive periods separate a wrong step size or sub-count order from a wrong compare, and the edge position at the period boundary exposes an off-by-one period. The smallest duties check the low-order duty bits. The duties at and past the period check the no-clear rule, and zero checks the no-set rule.

Directed runs cover three further cases. A duty rewrite lands mid-period and must wait for the boundary. A prescale rewrite lands mid-step and must stretch the period. Enable drops while the output is high and must force the output low and hold the timer.

// File: rtl/pwm10_pkg.sv
package pwm10_pkg;

  localparam int SUB_W = 6;

  typedef enum logic [1:0] {
    REG_PERIOD  = 2'd0,
    REG_DUTY_HI = 2'd1,
    REG_DUTY_LO = 2'd2,
    REG_PSEL    = 2'd3
  } reg_addr_e;

  // Last sub-count value of one timer step: 4 * prescale - 1 clocks.
  function automatic logic [SUB_W-1:0] sub_limit(input logic [1:0] psel);
    case (psel)
      2'b00:   sub_limit = 6'd3;
      2'b01:   sub_limit = 6'd15;
      default: sub_limit = 6'd63;
    endcase
  endfunction

  // Two fractional time-base bits: the top two bits of the sub-count.
  function automatic logic [1:0] ext_bits(input logic [1:0] psel,
                                          input logic [SUB_W-1:0] sub);
    case (psel)
      2'b00:   ext_bits = sub[1:0];
      2'b01:   ext_bits = sub[3:2];
      default: ext_bits = sub[5:4];
    endcase
  endfunction

endpackage

// File: rtl/pwm10_regs.sv
module pwm10_regs
  import pwm10_pkg::*;
#(
  parameter int TMR_W = 8,
  localparam int DUTY_W = TMR_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [TMR_W-1:0]  wr_data,
  output logic [TMR_W-1:0]  period,
  output logic [DUTY_W-1:0] duty_buf,
  output logic [1:0]        psel,
  output logic              psel_wr
);

  logic [TMR_W-1:0] duty_hi;
  logic [1:0]       duty_lo;

  assign psel_wr  = wr_en && (wr_addr == REG_PSEL);
  assign duty_buf = {duty_hi, duty_lo};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period  <= '0;
      duty_hi <= '0;
      duty_lo <= '0;
      psel    <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        REG_PERIOD:  period  <= wr_data;
        REG_DUTY_HI: duty_hi <= wr_data;
        REG_DUTY_LO: duty_lo <= wr_data[1:0];
        default:     psel    <= wr_data[1:0];
      endcase
    end
  end

endmodule

// File: rtl/pwm10_timebase.sv
module pwm10_timebase
  import pwm10_pkg::*;
#(
  parameter int TMR_W = 8,
  localparam int DUTY_W = TMR_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [1:0]        psel,
  input  logic              psel_wr,
  input  logic [TMR_W-1:0]  period,
  output logic              wrap_evt,
  output logic [DUTY_W-1:0] nxt_tb
);

  logic [TMR_W-1:0] tmr, nxt_tmr;
  logic [SUB_W-1:0] sub, nxt_sub;
  logic             en_q;
  logic             start_evt, step_end, roll_evt;

  assign start_evt = en && !en_q;
  assign step_end  = (sub == sub_limit(psel));
  assign roll_evt  = en && en_q && !psel_wr && step_end && (tmr == period);
  assign wrap_evt  = start_evt || roll_evt;

  always_comb begin
    nxt_tmr = tmr;
    nxt_sub = sub + 1'b1;
    if (!en || start_evt) begin
      nxt_tmr = '0;
      nxt_sub = '0;
    end else if (psel_wr) begin
      nxt_sub = '0;
    end else if (step_end) begin
      nxt_sub = '0;
      nxt_tmr = roll_evt ? '0 : tmr + 1'b1;
    end
  end

  assign nxt_tb = {nxt_tmr, ext_bits(psel, nxt_sub)};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr  <= '0;
      sub  <= '0;
      en_q <= 1'b0;
    end else begin
      tmr  <= nxt_tmr;
      sub  <= nxt_sub;
      en_q <= en;
    end
  end

  a_r1_wrap_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> (tmr == '0 && sub == '0));
  a_r2_sub_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    sub <= sub_limit(psel));
  a_r7_idle_holds_timer: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (tmr == '0 && sub == '0));

endmodule

// File: rtl/pwm10_outstage.sv
module pwm10_outstage #(
  parameter int TMR_W = 8,
  localparam int DUTY_W = TMR_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              wrap_evt,
  input  logic [DUTY_W-1:0] duty_buf,
  input  logic [DUTY_W-1:0] nxt_tb,
  output logic [DUTY_W-1:0] duty_act,
  output logic              pwm_out
);

  logic duty_zero, hit_evt;

  assign duty_zero = (duty_buf == '0);
  assign hit_evt   = (nxt_tb == duty_act);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      duty_act <= '0;
      pwm_out  <= 1'b0;
    end else begin
      if (!en || wrap_evt) duty_act <= duty_buf;
      if (!en)           pwm_out <= 1'b0;
      else if (wrap_evt) pwm_out <= !duty_zero;
      else if (hit_evt)  pwm_out <= 1'b0;
    end
  end

  a_r4_zero_duty_low: assert property (@(posedge clk) disable iff (!rst_n)
    (en && wrap_evt && duty_zero) |=> !pwm_out);
  a_r6_duty_held: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !wrap_evt) |=> $stable(duty_act));
  a_r7_disable_low: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !pwm_out);
  a_r1_period_start_high: assert property (@(posedge clk) disable iff (!rst_n)
    (en && wrap_evt && !duty_zero) |=> pwm_out);

endmodule

// File: rtl/pwm10_gen.sv
module pwm10_gen
  import pwm10_pkg::*;
#(
  parameter int TMR_W = 8,
  localparam int DUTY_W = TMR_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [TMR_W-1:0]  wr_data,
  output logic              pwm_out,
  output logic [DUTY_W-1:0] duty_active
);

  logic [TMR_W-1:0]  period;
  logic [DUTY_W-1:0] duty_buf;
  logic [DUTY_W-1:0] nxt_tb;
  logic [1:0]        psel;
  logic              psel_wr;
  logic              wrap_evt;

  pwm10_regs #(.TMR_W(TMR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .period(period), .duty_buf(duty_buf),
    .psel(psel), .psel_wr(psel_wr)
  );

  pwm10_timebase #(.TMR_W(TMR_W)) u_tb (
    .clk(clk), .rst_n(rst_n), .en(en), .psel(psel), .psel_wr(psel_wr),
    .period(period), .wrap_evt(wrap_evt), .nxt_tb(nxt_tb)
  );

  pwm10_outstage #(.TMR_W(TMR_W)) u_out (
    .clk(clk), .rst_n(rst_n), .en(en), .wrap_evt(wrap_evt),
    .duty_buf(duty_buf), .nxt_tb(nxt_tb), .duty_act(duty_active),
    .pwm_out(pwm_out)
  );

endmodule

// File: tb/pwm10_gen_bench.sv
module pwm10_gen_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       pwm_out;
  logic [9:0] duty_active;

  int n_chk = 0;
  int n_bad = 0;
  logic smp [0:2047];

  always #10 clk = ~clk;

  pwm10_gen u_pwm10_gen (
    .clk(clk), .rst_n(rst_n), .en(en), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pwm_out(pwm_out), .duty_active(duty_active)
  );

  function automatic int pre_of(input int ps);
    return (ps == 0) ? 1 : (ps == 1) ? 4 : 16;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic setup(input int p, input int ps, input int duty);
    @(negedge clk);
    en = 1'b0;
    wr(2'd0, 8'(p));
    wr(2'd1, 8'(duty >> 2));
    wr(2'd2, 8'(duty & 3));
    wr(2'd3, 8'(ps));
    en = 1'b1;
    @(posedge clk);
  endtask

  task automatic run_cfg(input int p, input int ps, input int duty);
    int steps, per, exp_hi, hi1, hi2;
    string req;
    steps = 4 * (p + 1);
    per   = steps * pre_of(ps);
    setup(p, ps, duty);
    hi1 = 0; hi2 = 0;
    for (int i = 0; i <= 2 * per; i++) begin
      @(negedge clk);
      smp[i] = pwm_out;
      if (i < per) hi1 += int'(pwm_out);
      else if (i < 2 * per) hi2 += int'(pwm_out);
    end
    if (duty == 0) begin
      exp_hi = 0; req = "R4";
    end else if (duty >= steps) begin
      exp_hi = per; req = "R5";
    end else begin
      exp_hi = duty * pre_of(ps); req = "R3";
    end
    chk(hi1 == exp_hi, req, hi1, exp_hi);
    chk(hi2 == exp_hi, "R1 second period", hi2, exp_hi);
    chk(int'(duty_active) == duty, "R7 duty loaded", int'(duty_active), duty);
    if (duty > 0 && duty < steps) begin
      chk(smp[per - 1] == 1'b0, "R1 end of period low", int'(smp[per - 1]), 0);
      chk(smp[per] == 1'b1, "R1 next period starts", int'(smp[per]), 1);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int pl[4];
    int hi;
    pl = '{0, 1, 2, 5};
    repeat (3) @(negedge clk);
    // R8: reset state
    chk(pwm_out == 1'b0, "R8 out", int'(pwm_out), 0);
    chk(duty_active == '0, "R8 duty", int'(duty_active), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(pwm_out == 1'b0, "R8 idle out", int'(pwm_out), 0);

    // R1 R2 R3 R4 R5: sweep
    foreach (pl[k]) begin
      for (int ps = 0; ps < 4; ps++) begin
        int st;
        int dl[10];
        st = 4 * (pl[k] + 1);
        dl = '{0, 1, 2, 3, 4, 5, st / 2, st - 1, st, 1023};
        foreach (dl[j]) run_cfg(pl[k], ps, dl[j]);
      end
    end

    // R6: duty rewrite mid-period, old value 5, new value 9
    setup(3, 0, 5);
    hi = 0;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      hi += int'(pwm_out);
      if (i == 3) begin wr_en = 1'b1; wr_addr = 2'd1; wr_data = 8'd2; end
      if (i == 4) begin wr_addr = 2'd2; wr_data = 8'd1; end
      if (i == 5) wr_en = 1'b0;
      if (i == 15) chk(duty_active == 10'd5, "R6 active held", int'(duty_active), 5);
    end
    chk(hi == 5, "R6 current period", hi, 5);
    hi = 0;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      hi += int'(pwm_out);
      if (i == 0) chk(duty_active == 10'd9, "R6 latched at boundary", int'(duty_active), 9);
    end
    chk(hi == 9, "R6 next period", hi, 9);

    // R2: prescale rewrite mid-step restarts the step count
    setup(0, 1, 2);
    hi = 0;
    for (int i = 0; i <= 22; i++) begin
      @(negedge clk);
      smp[i] = pwm_out;
      if (i < 22) hi += int'(pwm_out);
      if (i == 5) begin wr_en = 1'b1; wr_addr = 2'd3; wr_data = 8'd1; end
      if (i == 6) wr_en = 1'b0;
    end
    chk(hi == 14, "R2 stretched high time", hi, 14);
    chk(smp[22] == 1'b1, "R2 stretched period", int'(smp[22]), 1);

    // R7: disable while high
    setup(3, 0, 10);
    repeat (3) @(negedge clk);
    chk(pwm_out == 1'b1, "R7 running high", int'(pwm_out), 1);
    en = 1'b0;
    @(negedge clk);
    chk(pwm_out == 1'b0, "R7 disabled low", int'(pwm_out), 0);
    hi = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      hi += int'(pwm_out);
    end
    chk(hi == 0, "R7 stays low", hi, 0);
    en = 1'b1;
    @(negedge clk);
    chk(pwm_out == 1'b1, "R7 restart high", int'(pwm_out), 1);
    hi = 1;
    for (int i = 1; i < 16; i++) begin
      @(negedge clk);
      hi += int'(pwm_out);
    end
    chk(hi == 10, "R7 fresh period", hi, 10);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule